// File: doc/BRIEF.md
# ISA Bus Memory Refresh Sequencer

This block runs memory refresh cycles on an ISA-style expansion bus. A refresh request can come from two places. The first is a one-clock tick from an external interval timer, which fires about every 15 µs. The second is a refresh strobe from a foreign bus master that currently owns the bus. For each cycle the block drives the refresh indicator, an 8-bit row address, the memory read strobes and the address-latch and address-enable lines. A low ready input stretches the cycle.

Timer ticks go into a saturating pending counter that holds up to four requests. While a foreign master owns the bus, ticks are only counted. When ownership returns, every queued request is run back to back. A hold output stays high for every clock of a refresh cycle, so that a host-side arbiter stalls transfers aimed at the bus. The block never drives the data bus.

Top module: `isa_refresh_ctrl`

## Requirements
- R1: The asynchronous active-low reset clears the pending count and the row counter and returns the sequencer to idle. While reset is applied and afterwards, `rfsh_no`, `memr_no` and `smemr_no` are high, and `hold_o`, `aen_o`, `bale_o`, `addr_oe_o` and `data_oe_o` are low.
- R2: The pending counter saturates at four. A tick that arrives while it already holds four, in a clock with no completion, is dropped.
- R3: While `bus_own_i` is low, ticks start no cycle and are only queued. Once `bus_own_i` is high, all queued requests run consecutively: RECOVER goes straight to the next ADDR, and `hold_o` does not drop between them.
- R4: In a timer-sourced cycle, `rfsh_no` is low from ADDR through RECOVER. `memr_no` and `smemr_no` are both low during STROBE. `aen_o` and `bale_o` are high for the whole cycle.
- R5: With `bus_own_i` low, a low `mst_rfsh_ni` seen in idle starts a master-sourced cycle. In that cycle only `memr_no` strobes, `smemr_no` stays high, `rfsh_no` stays released (high), `bale_o` is high and `aen_o` is low for the whole cycle.
- R6: A cycle is ADDR for 1 clock, then STROBE for a minimum of 4 clocks, then RECOVER for 1 clock.
- R7: While `ready_i` is low, STROBE continues. It ends on the first clock edge at which the minimum length has been reached and `ready_i` is high.
- R8: `hold_o` is high on every clock from ADDR through RECOVER and low in idle.
- R9: `data_oe_o` is always low.
- R10: `row_addr_o` shows the row counter. The counter increments by one after every completed cycle of either source and wraps from 0xFF to 0x00. `addr_oe_o` is high for the whole cycle.
- R11: A tick in the same clock as the completion of a timer-sourced cycle leaves the pending count unchanged, so the next cycle follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock refresh request from the interval timer |
| bus_own_i | input | 1 | High when the block owns the bus, low when a foreign master owns it |
| mst_rfsh_ni | input | 1 | Refresh request from the foreign master, active low |
| ready_i | input | 1 | Bus ready; low stretches the strobe phase |
| rfsh_no | output | 1 | Refresh indicator for timer-sourced cycles, active low |
| row_addr_o | output | 8 | Refresh row address |
| addr_oe_o | output | 1 | Row address drive enable |
| memr_no | output | 1 | Memory read strobe, active low |
| smemr_no | output | 1 | Low-memory read strobe, active low |
| aen_o | output | 1 | Address enable |
| bale_o | output | 1 | Address latch enable |
| hold_o | output | 1 | Stall request to the host arbiter while a cycle runs |
| data_oe_o | output | 1 | Data bus drive enable (always low) |

## Verification
The bench pushes zero to seven ticks into the queue while the bus is owned by a foreign master. It then checks that exactly min(n,4) cycles follow with one unbroken hold. A counter that fails to saturate would replay too many cycles, and one that is not gated by ownership would raise hold too early. A tick placed exactly on a completion edge must give an immediate second cycle; a design that drops the tick or counts it twice would show a gap or a third cycle. The bench also checks three further cases, each with the failure it would expose:
- The strobe length with ready held low. A design that does not honour ready closes the strobe after four clocks.
- The master-cycle signal pattern. A design that mixes up the two patterns strobes the low-memory line or raises the address enable.
- The row address wrapping after 256 cycles. A design with the wrong counter width carries into a ninth bit or stops at 0xFF.

// File: rtl/isa_rfsh_pkg.sv
package isa_rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ADDR    = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } rfsh_state_e;

  typedef enum logic {
    SRC_TIMER  = 1'b0,
    SRC_MASTER = 1'b1
  } rfsh_src_e;
endpackage

// File: rtl/rfsh_queue.sv
module rfsh_queue #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic done_i,
  output logic queued_o,
  output logic more_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (tick_i && !done_i) begin
      if (pend_q != FULL) pend_d = pend_q + 1'b1;
    end else if (done_i && !tick_i) begin
      if (pend_q != '0) pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign queued_o = (pend_q != '0);
  assign more_o   = (pend_d != '0);

  assert_drop_at_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == FULL && tick_i && !done_i) |=> (pend_q == FULL));

  assert_tick_on_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && done_i) |=> $stable(pend_q));

  assert_done_drains_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !tick_i && pend_q != '0) |=> (pend_q == $past(pend_q) - 1'b1));
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;

  assert_row_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && row_q == '1) |=> (row_q == '0));

  assert_row_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_q));
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import isa_rfsh_pkg::*;
#(
  parameter int unsigned MIN_STROBE = 4,
  localparam int unsigned CNT_W     = (MIN_STROBE > 2) ? $clog2(MIN_STROBE) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_own_i,
  input  logic        mst_rfsh_ni,
  input  logic        ready_i,
  input  logic        queued_i,
  input  logic        more_i,
  output rfsh_state_e state_o,
  output rfsh_src_e   src_o,
  output logic        done_int_o,
  output logic        done_any_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_STROBE - 1);

  rfsh_state_e      state_q, state_d;
  rfsh_src_e        src_q, src_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (bus_own_i && queued_i) begin
          state_d = ST_ADDR;
          src_d   = SRC_TIMER;
        end else if (!bus_own_i && !mst_rfsh_ni) begin
          state_d = ST_ADDR;
          src_d   = SRC_MASTER;
        end
      end
      ST_ADDR: begin
        state_d = ST_STROBE;
        cnt_d   = '0;
      end
      ST_STROBE: begin
        if (cnt_q == LAST) begin
          if (ready_i) state_d = ST_RECOVER;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECOVER: begin
        // chain queued timer requests without passing through idle
        if (src_q == SRC_TIMER && bus_own_i && more_i) begin
          state_d = ST_ADDR;
          src_d   = SRC_TIMER;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_TIMER;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o    = state_q;
  assign src_o      = src_q;
  assign done_any_o = (state_q == ST_RECOVER);
  assign done_int_o = (state_q == ST_RECOVER) && (src_q == SRC_TIMER);

  assert_ready_stretch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && !ready_i) |=> (state_q == ST_STROBE));

  assert_addr_one_clk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR) |=> (state_q == ST_STROBE));

  assert_recover_after_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECOVER) |-> ($past(state_q) == ST_STROBE));

  assert_no_timer_start_unowned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !bus_own_i) |=> (state_q == ST_IDLE || src_q == SRC_MASTER));
endmodule

// File: rtl/isa_refresh_ctrl.sv
module isa_refresh_ctrl
  import isa_rfsh_pkg::*;
#(
  parameter int unsigned QUEUE_DEPTH = 4,
  parameter int unsigned ROW_W       = 8,
  parameter int unsigned MIN_STROBE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             bus_own_i,
  input  logic             mst_rfsh_ni,
  input  logic             ready_i,
  output logic             rfsh_no,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             addr_oe_o,
  output logic             memr_no,
  output logic             smemr_no,
  output logic             aen_o,
  output logic             bale_o,
  output logic             hold_o,
  output logic             data_oe_o
);
  rfsh_state_e state;
  rfsh_src_e   src;
  logic        queued, more, done_int, done_any;

  rfsh_queue #(.DEPTH(QUEUE_DEPTH)) u_queue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .done_i   (done_int),
    .queued_o (queued),
    .more_o   (more)
  );

  rfsh_seq #(.MIN_STROBE(MIN_STROBE)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_own_i   (bus_own_i),
    .mst_rfsh_ni (mst_rfsh_ni),
    .ready_i     (ready_i),
    .queued_i    (queued),
    .more_i      (more),
    .state_o     (state),
    .src_o       (src),
    .done_int_o  (done_int),
    .done_any_o  (done_any)
  );

  rfsh_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (done_any),
    .row_o  (row_addr_o)
  );

  logic busy, strobe, from_timer;

  assign busy       = (state != ST_IDLE);
  assign strobe     = (state == ST_STROBE);
  assign from_timer = (src == SRC_TIMER);

  assign hold_o    = busy;
  assign addr_oe_o = busy;
  assign bale_o    = busy;
  assign aen_o     = busy && from_timer;
  assign rfsh_no   = !(busy && from_timer);
  assign memr_no   = !strobe;
  assign smemr_no  = !(strobe && from_timer);
  assign data_oe_o = 1'b0;

  assert_timer_pattern_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_no |-> (aen_o && bale_o && addr_oe_o && (memr_no == smemr_no)));

  assert_master_pattern_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && rfsh_no) |-> (!aen_o && bale_o && smemr_no));

  assert_strobe_in_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!memr_no || !smemr_no) |-> hold_o);

  assert_no_data_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !data_oe_o);
endmodule

// File: tb/sim_isa_refresh_ctrl.sv
`timescale 1ns/100ps
module sim_isa_refresh_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       bus_own_i = 1'b1;
  logic       mst_rfsh_ni = 1'b1;
  logic       ready_i = 1'b1;
  logic       rfsh_no, addr_oe_o, memr_no, smemr_no, aen_o, bale_o, hold_o, data_oe_o;
  logic [7:0] row_addr_o;

  int errors = 0;
  int checks = 0;
  int exp_row = 0;
  int doe_seen = 0;
  int hold_falls = 0;
  logic prev_hold = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  isa_refresh_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .bus_own_i(bus_own_i),
    .mst_rfsh_ni(mst_rfsh_ni), .ready_i(ready_i), .rfsh_no(rfsh_no),
    .row_addr_o(row_addr_o), .addr_oe_o(addr_oe_o), .memr_no(memr_no),
    .smemr_no(smemr_no), .aen_o(aen_o), .bale_o(bale_o), .hold_o(hold_o),
    .data_oe_o(data_oe_o)
  );

  // high nibble: ticks while unowned, low nibble: cycles expected afterwards
  localparam logic [7:0] VEC [7] = '{8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h54, 8'h74};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    if (data_oe_o) doe_seen++;
    if (prev_hold && !hold_o) hold_falls++;
    prev_hold = hold_o;
  endtask

  task automatic pulse_tick();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int strobe_len;
    int row0;
    // R1 reset state
    #12;
    chk("R1 rfsh_no", rfsh_no, 1);
    chk("R1 memr_no", memr_no, 1);
    chk("R1 smemr_no", smemr_no, 1);
    chk("R1 hold", hold_o, 0);
    chk("R1 aen/bale/oe", {aen_o, bale_o, addr_oe_o}, 0);
    chk("R1 row", row_addr_o, 0);
    rst_ni = 1'b1;
    step(); step();
    chk("R1 idle after reset", hold_o, 0);

    // R4 R6 R8 R10 single timer cycle
    pulse_tick();
    chk("R8 idle before start", hold_o, 0);
    step();
    chk("R4 rfsh first", rfsh_no, 0);
    chk("R6 addr no strobe", memr_no, 1);
    chk("R4 aen bale", {aen_o, bale_o}, 3);
    chk("R8 hold addr", hold_o, 1);
    chk("R10 addr_oe", addr_oe_o, 1);
    strobe_len = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (memr_no) break;
      strobe_len++;
      chk("R4 smemr with memr", smemr_no, 0);
    end
    chk("R6 strobe len", strobe_len, 4);
    chk("R6 recover rfsh", rfsh_no, 0);
    chk("R8 hold recover", hold_o, 1);
    step();
    exp_row++;
    chk("R8 hold idle", hold_o, 0);
    chk("R10 row inc", row_addr_o, exp_row);

    // R5 master cycle
    bus_own_i = 1'b0;
    mst_rfsh_ni = 1'b0;
    step();
    mst_rfsh_ni = 1'b1;
    chk("R5 rfsh released", rfsh_no, 1);
    chk("R5 aen low", aen_o, 0);
    chk("R5 bale high", bale_o, 1);
    chk("R8 hold master", hold_o, 1);
    strobe_len = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (memr_no) break;
      strobe_len++;
      chk("R5 smemr idle", smemr_no, 1);
      chk("R5 aen low strobe", aen_o, 0);
    end
    chk("R6 master strobe len", strobe_len, 4);
    step();
    exp_row++;
    chk("R5 row inc", row_addr_o, exp_row);
    chk("R5 back idle", hold_o, 0);
    bus_own_i = 1'b1;

    // R7 ready stretch
    ready_i = 1'b0;
    pulse_tick();
    step();
    repeat (10) step();
    chk("R7 stretched", memr_no, 0);
    ready_i = 1'b1;
    step();
    chk("R7 ends on ready", memr_no, 1);
    chk("R7 recover hold", hold_o, 1);
    step();
    exp_row++;
    chk("R7 row", row_addr_o, exp_row);

    // R11 tick on completion edge
    pulse_tick();
    step();
    repeat (4) step();
    step();
    chk("R11 at recover", memr_no, 1);
    prev_hold = hold_o;
    hold_falls = 0;
    pulse_tick();
    chk("R11 next addr", rfsh_no, 0);
    chk("R11 hold kept", hold_o, 1);
    repeat (10) step();
    exp_row += 2;
    chk("R11 two cycles", row_addr_o, exp_row);
    chk("R11 one hold", hold_falls, 1);

    // R2 R3 table: queue while unowned, replay on ownership
    foreach (VEC[v]) begin
      bus_own_i = 1'b0;
      for (int t = 0; t < int'(VEC[v][7:4]); t++) begin
        pulse_tick();
        step();
      end
      chk($sformatf("R3 no service unowned v%0d", v), hold_o, 0);
      row0 = row_addr_o;
      hold_falls = 0;
      bus_own_i = 1'b1;
      repeat (40) step();
      chk($sformatf("R2 replay count v%0d", v), (row_addr_o - row0) & 8'hFF,
          int'(VEC[v][3:0]));
      chk($sformatf("R3 back to back v%0d", v), hold_falls,
          (VEC[v][3:0] != 0) ? 1 : 0);
      exp_row = (exp_row + int'(VEC[v][3:0])) & 8'hFF;
    end
    chk("R10 row after table", row_addr_o, exp_row);

    // R1 async reset mid strobe
    pulse_tick();
    step(); step();
    chk("R1 pre reset strobe", memr_no, 0);
    rst_ni = 1'b0;
    #1;
    chk("R1 async memr", memr_no, 1);
    chk("R1 async hold", hold_o, 0);
    chk("R1 async row", row_addr_o, 0);
    step();
    rst_ni = 1'b1;
    step();

    // R10 wrap
    for (int k = 0; k < 256; k++) begin
      pulse_tick();
      repeat (7) step();
      if (k == 254) chk("R10 row ff", row_addr_o, 255);
    end
    chk("R10 wrap", row_addr_o, 0);

    chk("R9 data_oe never", doe_seen, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule